// File: doc/BRIEF.md
# Sequential Shift-Subtract Divider

This block divides an unsigned dividend of twice the quotient width by an unsigned divisor of quotient width. It uses a single register one bit wider than the dividend. Each round shifts the register left by one. When the top bits of the shifted register are not smaller than the divisor, the block subtracts the divisor from them and writes a 1 into the bit that the shift left empty. After the last round, the low half of the register holds the quotient and the high half holds the remainder.

Before any round, the block compares the upper half of the dividend with the divisor. If the upper half is equal or larger, the quotient cannot fit. The block then raises an overflow flag, skips the rounds and finishes at once. A zero divisor always gives overflow. A single subtracter serves both the overflow test and the per-round decision: its no-borrow output acts as the comparison result. A one-hot controller sequences the work. A pulse on `start` loads new operands whenever the block is idle or finished. `done` then stays high, and the outputs stay frozen, until the next start.

Top module: `shift_sub_divider`

## Requirements
- R1: After reset, `done` and `overflow` are 0 and `quotient` and `remainder` read 0.
- R2: If the upper half of the dividend is equal to or larger than the divisor, `overflow` and `done` rise 2 clock edges after the start edge. No division takes place: `quotient` shows dividend bits [3:0] and `remainder` shows dividend bits [7:4].
- R3: A divisor of 0 always reports overflow.
- R4: Without overflow, `quotient`·divisor + `remainder` equals the dividend, and `remainder` is less than the divisor.
- R5: Without overflow, `done` rises 2 + QW + (number of 1 bits in the quotient) edges after the start edge. That is one shift per round, plus one subtract cycle for each quotient bit that is 1.
- R6: While `done` is high and `start` is low, `done`, `overflow`, `quotient` and `remainder` hold their values.
- R7: A `start` pulse during a division is ignored. The result and the latency are those of the operands loaded at the first start.
- R8: A `start` while `done` is high begins a new division. One edge later, `done` and `overflow` are 0.
- R9: The worked case 135 ÷ 13 gives quotient 10 and remainder 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Loads operands and begins a division when idle or done |
| dividend | input | 2·QW | Unsigned dividend |
| divisor | input | QW | Unsigned divisor |
| quotient | output | QW | Low half of the working register |
| remainder | output | QW | Upper half of the working register |
| overflow | output | 1 | Quotient would not fit; no division done |
| done | output | 1 | Result valid, held until the next start |

## Verification
The bench builds the block with QW = 4, so the dividend is 8 bits and the divisor is 4 bits. At that size, all 4096 operand pairs are few enough to run in full. Every overflow boundary, every zero divisor and every quotient bit pattern is therefore exercised. This also checks the data-dependent latency against the popcount of each quotient.

// File: rtl/shift_sub_divider.sv
module shift_sub_divider #(
  parameter int QW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic [QW-1:0]   quotient,
  output logic [QW-1:0]   remainder,
  output logic            overflow,
  output logic            done
);
  localparam int XW = 2*QW + 1;
  localparam int CW = (QW > 2) ? $clog2(QW) : 1;
  localparam int S_IDLE = 0;
  localparam int S_CHK  = 1;
  localparam int S_CMP  = 2;
  localparam int S_FIN  = 3;

  logic [3:0]    st;
  logic [XW-1:0] x;
  logic [QW-1:0] dvs;
  logic [CW-1:0] rnd;
  logic          ovf;
  logic [QW+1:0] diff;
  logic          nob;
  logic          last;

  assign diff = {1'b0, x[XW-1:QW]} - {2'b00, dvs};
  assign nob  = ~diff[QW+1];
  assign last = (rnd == CW'(QW-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= 4'b0001;
      x   <= '0;
      dvs <= '0;
      rnd <= '0;
      ovf <= 1'b0;
    end else if ((st[S_IDLE] || st[S_FIN]) && start) begin
      x   <= {1'b0, dividend};
      dvs <= divisor;
      rnd <= '0;
      ovf <= 1'b0;
      st  <= 4'b0010;
    end else if (st[S_CHK]) begin
      if (nob) begin
        ovf <= 1'b1;
        st  <= 4'b1000;
      end else begin
        x  <= x << 1;
        st <= 4'b0100;
      end
    end else if (st[S_CMP]) begin
      if (nob) begin
        x <= {diff[QW:0], x[QW-1:1], 1'b1};
      end else if (last) begin
        st <= 4'b1000;
      end else begin
        x   <= x << 1;
        rnd <= rnd + 1'b1;
      end
    end
  end

  assign quotient  = x[QW-1:0];
  assign remainder = x[2*QW-1:QW];
  assign overflow  = ovf;
  assign done      = st[S_FIN];
endmodule

module shift_sub_divider_chk #(
  parameter int QW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          overflow,
  input logic [QW-1:0] quotient,
  input logic [QW-1:0] remainder,
  input logic [QW-1:0] dvs
);
  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(quotient) && $stable(remainder) && $stable(overflow)));
  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (!done && !overflow));
  // R2
  overflow_done_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> done);
  // R2
  overflow_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (done && overflow) |-> (remainder >= dvs));
  // R4
  rem_small_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !overflow) |-> (remainder < dvs));
endmodule

bind shift_sub_divider shift_sub_divider_chk #(.QW(QW)) i_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .overflow(overflow),
  .quotient(quotient), .remainder(remainder), .dvs(dvs)
);

// File: tb/test_shift_sub_divider.sv
module test_shift_sub_divider;
  localparam int QW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [7:0]    dividend = '0;
  logic [3:0]    divisor = '0;
  logic [3:0]    quotient, remainder;
  logic          overflow, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  shift_sub_divider #(.QW(QW)) i_shift_sub_divider (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .overflow(overflow), .done(done)
  );

  // {dividend, divisor, quotient, remainder, overflow}
  localparam logic [20:0] VEC [8] = '{
    {8'd135, 4'd13, 4'd10, 4'd5,  1'b0},
    {8'd200, 4'd15, 4'd13, 4'd5,  1'b0},
    {8'd0,   4'd1,  4'd0,  4'd0,  1'b0},
    {8'd15,  4'd1,  4'd15, 4'd0,  1'b0},
    {8'd16,  4'd1,  4'd0,  4'd1,  1'b1},
    {8'd100, 4'd0,  4'd4,  4'd6,  1'b1},
    {8'd239, 4'd15, 4'd15, 4'd14, 1'b0},
    {8'd34,  4'd6,  4'd5,  4'd4,  1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] dd, input logic [3:0] dv, input bit poke, output int n);
    @(negedge clk);
    dividend = dd; divisor = dv; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (poke) begin dividend = ~dd; divisor = dv ^ 4'hF; end
    while (!done && n < 100) begin
      start = (poke && n == 2);
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
  endtask

  task automatic check_op(input logic [7:0] dd, input logic [3:0] dv, input bit poke, input string tag);
    int n, eq, er, eo, el;
    run_op(dd, dv, poke, n);
    eo = ((dd >> 4) >= dv) ? 1 : 0;
    if (eo) begin
      eq = dd & 15; er = dd >> 4; el = 2;
    end else begin
      eq = dd / dv; er = dd % dv; el = 2 + QW + $countones(eq[3:0]);
    end
    chk(overflow == eo, eo ? ((dv == 0) ? "R3" : "R2") : "R4", {tag, " overflow"}, overflow, eo);
    chk(quotient == eq, eo ? "R2" : "R4", {tag, " quotient"}, quotient, eq);
    chk(remainder == er, eo ? "R2" : "R4", {tag, " remainder"}, remainder, er);
    chk(n == el, eo ? "R2" : "R5", {tag, " latency"}, n, el);
  endtask

  initial begin
    int cyc_lim;
    cyc_lim = 150000;
    wait (cyc > cyc_lim);
    chk(1'b0, "watchdog", "cycles", cyc, cyc_lim);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(overflow == 1'b0, "R1", "overflow", overflow, 0);
    chk(quotient == 4'd0, "R1", "quotient", quotient, 0);
    chk(remainder == 4'd0, "R1", "remainder", remainder, 0);

    for (int i = 0; i < 8; i++) begin
      logic [20:0] v;
      int n;
      v = VEC[i];
      run_op(v[20:13], v[12:9], 1'b0, n);
      chk(quotient == v[8:5], (i == 0) ? "R9" : "R4", "vector quotient", quotient, v[8:5]);
      chk(remainder == v[4:1], (i == 0) ? "R9" : "R4", "vector remainder", remainder, v[4:1]);
      chk(overflow == v[0], v[0] ? "R2" : "R4", "vector overflow", overflow, v[0]);
    end

    for (int dv = 0; dv < 16; dv++)
      for (int dd = 0; dd < 256; dd++)
        check_op(8'(dd), 4'(dv), 1'b0, "sweep");

    // R7 start pulse mid-division ignored
    check_op(8'd135, 4'd13, 1'b1, "R7 busy start");
    check_op(8'd119, 4'd9, 1'b1, "R7 busy start");

    // R6 hold while done and start low
    begin
      logic [3:0] hq, hr;
      check_op(8'd77, 4'd11, 1'b0, "R6 setup");
      hq = quotient; hr = remainder;
      repeat (6) @(negedge clk);
      chk(done == 1'b1, "R6", "done held", done, 1);
      chk(quotient == hq, "R6", "quotient held", quotient, hq);
      chk(remainder == hr, "R6", "remainder held", remainder, hr);
    end

    // R8 restart after overflow clears flags one edge later
    check_op(8'd250, 4'd3, 1'b0, "R8 setup");
    @(negedge clk);
    dividend = 8'd40; divisor = 4'd7; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8", "done after restart", done, 0);
    chk(overflow == 1'b0, "R8", "overflow after restart", overflow, 0);
    wait (done);
    @(negedge clk);
    chk(quotient == 4'd5 && remainder == 4'd5, "R8", "restart result q*16+r", quotient*16+remainder, 85);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule